// File: doc/BRIEF.md
# Interrupt Status and Cause Controller

This block keeps the two control registers a processor core uses to decide whether to take an interrupt: a Status register (global enable, per-line enable mask, exception-level and error-level flags) and a Cause register (per-line pending bits and software-settable pending bits). Request lines from peripherals arrive as numbered level events. A timer supplies a match pulse and a compare-write pulse. The block latches each request into its pending bit and produces one registered interrupt request for the core pipeline.

That request is derived from a single shared condition. At least one pending bit in Cause bits 15:8 must also have its enable set in Status bits 15:8. The global enable must be set, and none of the exception-level flag, the error-level flag or the debug-mode input may be active. The software pending bits written into Cause count exactly like hardware lines.

The core reads and writes the registers through a select, a write enable and a 32-bit data bus. Each register has fixed masks for its writable bits. Single-cycle enable and disable operations return the previous Status value. The interrupt controller for legacy devices uses request line 2, which is Cause bit 10, and the timer owns line 7, which is Cause bit 15.

Top module: `cp_irq_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads Cause with 0 and Status with 0x00000004 (error-level flag, bit 2, set; global enable, bit 0, clear), drives `irq_o` low and loads `rd_data` with 0.
- R2: A cycle with `req_valid` high and `req_num` n below 16 loads Cause bit n+8 with `req_level`. A request with n of 16 or more changes nothing.
- R3: `tmr_match` sets Cause bit 15 and `cmp_write` clears it. When both arrive in the same cycle the bit is cleared. Either timer pulse overrides a request on line 7 in the same cycle.
- R4: A Cause write (`wr_en` with `reg_sel`=1) takes bits in mask 0x00C00300 from `wr_data`, retains bits in mask 0xB000F87C, and clears every other bit. Request and timer events in the same cycle are applied after the write.
- R5: A Status write (`wr_en` with `reg_sel`=0) stores `wr_data` AND 0xFA78FF01. It keeps the exception-level flag (bit 1) and the error-level flag (bit 2), and it clears every other bit.
- R6: `op_di` clears Status bit 0, leaves the other bits unchanged, and returns the previous Status value on `rd_data` in the next cycle.
- R7: `op_ei` sets Status bit 0, leaves the other bits unchanged, and returns the previous Status value on `rd_data` in the next cycle.
- R8: After each clock edge, `irq_o` is high exactly when the following held in the cycle before that edge: (Status AND Cause AND 0x0000FF00) was nonzero, Status bit 0 was 1, Status bits 1 and 2 were 0, and `dbg_mode` was 0.
- R9: Pending bits 9:8 written through Cause raise `irq_o` under the same enable and gating rules as the hardware lines.
- R10: In any cycle without `op_ei` or `op_di`, `rd_data` after the next edge holds the value the selected register (0 Status, 1 Cause) had before that edge.
- R11: `exc_return` clears Status bit 2 if it is set, and otherwise clears bit 1. `exc_enter` sets bit 1. When both pulses arrive, the return is applied first and the entry second, and both are applied after any register operation in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 Status, 1 Cause |
| wr_en | input | 1 | Write the selected register with `wr_data` |
| op_ei | input | 1 | Set global enable, return old Status |
| op_di | input | 1 | Clear global enable, return old Status |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Read data, one cycle after the access |
| req_valid | input | 1 | A request line event is present |
| req_num | input | 5 | Request line number |
| req_level | input | 1 | New level of the request line |
| tmr_match | input | 1 | Timer count reached compare value |
| cmp_write | input | 1 | Timer compare register was written |
| exc_enter | input | 1 | Exception entry: set exception-level flag |
| exc_return | input | 1 | Exception return: clear error-level, else exception-level flag |
| dbg_mode | input | 1 | Core is in debug mode |
| irq_o | output | 1 | Registered interrupt request to the pipeline |

## Verification
The assertions assume that at most one of `wr_en`, `op_ei` and `op_di` is high in any cycle. The precedence among them is defined, but it is not the intended use. The stimulus drives them only from a single operation choice per cycle, so a mixed cycle never occurs. The checks on ignored requests and on retained Cause bits also assume that no timer pulse or other request touches Cause in the same cycle, and the directed phases of the bench leave those inputs idle. Only the random phase combines timer pulses, request events and register writes freely, and there the reference model carries the full ordering.

// File: rtl/cp_irq_pkg.sv
// Shared constants for the interrupt status/cause controller.
// Assumes a 32-bit register width throughout.
package cp_irq_pkg;
    localparam int unsigned XLEN = 32;
    // register select encodings
    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_CAUSE  = 1'b1;
    // operation applied to Status in one cycle
    typedef enum logic [1:0] {
        SOP_NONE  = 2'd0,
        SOP_WRITE = 2'd1,
        SOP_EI    = 2'd2,
        SOP_DI    = 2'd3
    } status_op_e;
endpackage

// File: rtl/cp_irq_cause.sv
// Cause register: holds the pending bits for the request lines.
// Order inside one cycle: a software write first, then request-line events,
// then the timer match, then the compare write (last one wins).
// Assumes req_num carries the line number and the line count fits in 32 bits.
module cp_irq_cause
    import cp_irq_pkg::*;
#(
    parameter int unsigned NUM_REQ    = 16,
    parameter int unsigned REQ_W      = 5,
    parameter int unsigned PEND_LSB   = 8,
    parameter int unsigned TIMER_LINE = 7,
    parameter logic [XLEN-1:0] WMASK  = 32'h00C0_0300,
    parameter logic [XLEN-1:0] KEEP   = 32'hB000_F87C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             req_valid,
    input  logic [REQ_W-1:0] req_num,
    input  logic             req_level,
    input  logic             tmr_match,
    input  logic             cmp_write,
    output logic [XLEN-1:0]  cause_q
);
    localparam int unsigned TIMER_BIT = PEND_LSB + TIMER_LINE;

    logic [NUM_REQ-1:0] line_hit;
    logic [XLEN-1:0]    after_wr;
    logic [XLEN-1:0]    cause_d;

    // one decoder comparator per request line
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_line
        assign line_hit[g] = req_valid && (32'(req_num) == g);
    end

    // software write through the fixed masks
    always_comb begin
        after_wr = cause_q;
        if (wr_en) begin
            after_wr = (cause_q & KEEP) | (wr_data & WMASK);
        end
    end

    // hardware events layered on top of the software write
    always_comb begin
        cause_d = after_wr;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (line_hit[i]) begin
                cause_d[PEND_LSB + i] = req_level;
            end
        end
        if (tmr_match) begin
            cause_d[TIMER_BIT] = 1'b1;
        end
        if (cmp_write) begin
            cause_d[TIMER_BIT] = 1'b0;
        end
    end

    // register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_d;
        end
    end
endmodule

// File: rtl/cp_irq_status.sv
// Status register: global enable, enable mask and mode flags.
// Assumes at most one of wr_en / op_ei / op_di per cycle; if more arrive,
// write beats enable beats disable. Flag pulses are applied after the
// register operation: return first, then entry.
module cp_irq_status
    import cp_irq_pkg::*;
#(
    parameter logic [XLEN-1:0] WMASK     = 32'hFA78_FF01,
    parameter logic [XLEN-1:0] RESET_VAL = 32'h0000_0004,
    parameter int unsigned     IE_BIT    = 0,
    parameter int unsigned     EXL_BIT   = 1,
    parameter int unsigned     ERL_BIT   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            op_ei,
    input  logic            op_di,
    input  logic [XLEN-1:0] wr_data,
    input  logic            exc_enter,
    input  logic            exc_return,
    output logic [XLEN-1:0] status_q
);
    localparam logic [XLEN-1:0] FLAG_MASK =
        (XLEN'(1) << EXL_BIT) | (XLEN'(1) << ERL_BIT);

    status_op_e      sop;
    logic [XLEN-1:0] after_op;
    logic [XLEN-1:0] status_d;

    // choose the single register operation for this cycle
    always_comb begin
        if (wr_en)      sop = SOP_WRITE;
        else if (op_ei) sop = SOP_EI;
        else if (op_di) sop = SOP_DI;
        else            sop = SOP_NONE;
    end

    // apply the register operation
    always_comb begin
        after_op = status_q;
        case (sop)
            SOP_WRITE: after_op = (wr_data & WMASK) | (status_q & FLAG_MASK);
            SOP_EI:    after_op[IE_BIT] = 1'b1;
            SOP_DI:    after_op[IE_BIT] = 1'b0;
            default:   after_op = status_q;
        endcase
    end

    // apply the exception-flag pulses after the operation
    always_comb begin
        status_d = after_op;
        if (exc_return) begin
            if (after_op[ERL_BIT]) status_d[ERL_BIT] = 1'b0;
            else                   status_d[EXL_BIT] = 1'b0;
        end
        if (exc_enter) begin
            status_d[EXL_BIT] = 1'b1;
        end
    end

    // register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= RESET_VAL;
        end else begin
            status_q <= status_d;
        end
    end
endmodule

// File: rtl/cp_irq_gate.sv
// Interrupt gate: masks the pending lines with their enables, then blocks the
// result on the global enable and the mode flags, and registers the outcome.
// Assumes its inputs come from registers, so irq_o lags them by one cycle.
module cp_irq_gate #(
    parameter int unsigned PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] pend,
    input  logic [PEND_W-1:0] pend_en,
    input  logic              glob_en,
    input  logic              exl,
    input  logic              erl,
    input  logic              dbg_mode,
    output logic              irq_o
);
    logic [PEND_W-1:0] live;
    logic              any_live;
    logic              blocked;
    logic              raise;

    // per-line enable masking
    for (genvar g = 0; g < PEND_W; g++) begin : g_mask
        assign live[g] = pend[g] & pend_en[g];
    end

    // combine the lines and the gating terms
    always_comb begin
        any_live = |live;
        blocked  = !glob_en || exl || erl || dbg_mode;
        raise    = any_live && !blocked;
    end

    // registered request to the pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= raise;
        end
    end
endmodule

// File: rtl/cp_irq_unit.sv
// Top of the interrupt status/cause controller. Routes the register interface
// to the Status and Cause holders, feeds the gate and returns read data one
// cycle late. Assumes the caller issues at most one register operation a cycle.
module cp_irq_unit
    import cp_irq_pkg::*;
#(
    parameter int unsigned NUM_REQ      = 16,
    parameter int unsigned REQ_W        = 5,
    parameter int unsigned PEND_LSB     = 8,
    parameter int unsigned PEND_W       = 8,
    parameter int unsigned TIMER_LINE   = 7,
    parameter int unsigned IE_BIT       = 0,
    parameter int unsigned EXL_BIT      = 1,
    parameter int unsigned ERL_BIT      = 2,
    parameter logic [31:0] CAUSE_WMASK  = 32'h00C0_0300,
    parameter logic [31:0] CAUSE_KEEP   = 32'hB000_F87C,
    parameter logic [31:0] STATUS_WMASK = 32'hFA78_FF01,
    parameter logic [31:0] STATUS_RESET = 32'h0000_0004
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic             op_ei,
    input  logic             op_di,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic             req_valid,
    input  logic [REQ_W-1:0] req_num,
    input  logic             req_level,
    input  logic             tmr_match,
    input  logic             cmp_write,
    input  logic             exc_enter,
    input  logic             exc_return,
    input  logic             dbg_mode,
    output logic             irq_o
);
    logic [XLEN-1:0] status_w;
    logic [XLEN-1:0] cause_w;
    logic            cause_wr;
    logic            status_wr;

    // steer the write to the selected register
    always_comb begin
        cause_wr  = wr_en && (reg_sel == SEL_CAUSE);
        status_wr = wr_en && (reg_sel == SEL_STATUS);
    end

    cp_irq_cause #(
        .NUM_REQ    (NUM_REQ),
        .REQ_W      (REQ_W),
        .PEND_LSB   (PEND_LSB),
        .TIMER_LINE (TIMER_LINE),
        .WMASK      (CAUSE_WMASK),
        .KEEP       (CAUSE_KEEP)
    ) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cause_wr),
        .wr_data   (wr_data),
        .req_valid (req_valid),
        .req_num   (req_num),
        .req_level (req_level),
        .tmr_match (tmr_match),
        .cmp_write (cmp_write),
        .cause_q   (cause_w)
    );

    cp_irq_status #(
        .WMASK     (STATUS_WMASK),
        .RESET_VAL (STATUS_RESET),
        .IE_BIT    (IE_BIT),
        .EXL_BIT   (EXL_BIT),
        .ERL_BIT   (ERL_BIT)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (status_wr),
        .op_ei      (op_ei),
        .op_di      (op_di),
        .wr_data    (wr_data),
        .exc_enter  (exc_enter),
        .exc_return (exc_return),
        .status_q   (status_w)
    );

    cp_irq_gate #(
        .PEND_W (PEND_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (cause_w[PEND_LSB +: PEND_W]),
        .pend_en  (status_w[PEND_LSB +: PEND_W]),
        .glob_en  (status_w[IE_BIT]),
        .exl      (status_w[EXL_BIT]),
        .erl      (status_w[ERL_BIT]),
        .dbg_mode (dbg_mode),
        .irq_o    (irq_o)
    );

    // read data: old Status for enable/disable, otherwise the selected register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (op_ei || op_di) begin
            rd_data <= status_w;
        end else begin
            rd_data <= (reg_sel == SEL_CAUSE) ? cause_w : status_w;
        end
    end
endmodule

// File: rtl/cp_irq_chk.sv
// Checker for cp_irq_unit: temporal properties across the Status holder,
// the Cause holder and the registered request. Attached by bind below.
module cp_irq_chk
    import cp_irq_pkg::*;
#(
    parameter int unsigned NUM_REQ      = 16,
    parameter int unsigned REQ_W        = 5,
    parameter int unsigned PEND_LSB     = 8,
    parameter int unsigned TIMER_LINE   = 7,
    parameter int unsigned IE_BIT       = 0,
    parameter int unsigned EXL_BIT      = 1,
    parameter int unsigned ERL_BIT      = 2,
    parameter logic [31:0] CAUSE_KEEP   = 32'hB000_F87C,
    parameter logic [31:0] STATUS_RESET = 32'h0000_0004
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic             wr_en,
    input logic             op_ei,
    input logic             op_di,
    input logic             req_valid,
    input logic [REQ_W-1:0] req_num,
    input logic             tmr_match,
    input logic             cmp_write,
    input logic             exc_enter,
    input logic             exc_return,
    input logic             dbg_mode,
    input logic [31:0]      status_w,
    input logic [31:0]      cause_w,
    input logic             irq_o
);
    localparam int unsigned TB = PEND_LSB + TIMER_LINE;

    // reset state, R1
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && cause_w == '0 && status_w == STATUS_RESET));

    // out-of-range request leaves Cause untouched, R2
    assert_ignored_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && 32'(req_num) >= NUM_REQ && !(wr_en && reg_sel == SEL_CAUSE)
         && !tmr_match && !cmp_write) |=> $stable(cause_w));

    // compare write clears the timer pending bit, R3
    assert_compare_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_write |=> !cause_w[TB]);

    // match sets the timer pending bit, R3
    assert_match_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_match && !cmp_write) |=> cause_w[TB]);

    // Cause write retains the kept field, R4
    assert_cause_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_CAUSE && !req_valid && !tmr_match && !cmp_write)
        |=> ((cause_w & CAUSE_KEEP) == ($past(cause_w) & CAUSE_KEEP)));

    // Status write keeps the mode flags, R5
    assert_status_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_STATUS && !exc_enter && !exc_return)
        |=> (status_w[EXL_BIT] == $past(status_w[EXL_BIT])
             && status_w[ERL_BIT] == $past(status_w[ERL_BIT])));

    // input assumption: one register operation per cycle, R6
    assert_single_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, op_ei, op_di}));

    // disable clears the global enable, R6
    assert_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_di |=> !status_w[IE_BIT]);

    // enable sets the global enable, R7
    assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_ei |=> status_w[IE_BIT]);

    // a raised request implies the gating terms held a cycle earlier, R8
    assert_request_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(status_w[IE_BIT]) && !$past(status_w[EXL_BIT])
                   && !$past(status_w[ERL_BIT]) && !$past(dbg_mode)));

    // entry pulse always leaves the exception-level flag set, R11
    assert_entry_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> status_w[EXL_BIT]);
endmodule

bind cp_irq_unit cp_irq_chk #(
    .NUM_REQ      (NUM_REQ),
    .REQ_W        (REQ_W),
    .PEND_LSB     (PEND_LSB),
    .TIMER_LINE   (TIMER_LINE),
    .IE_BIT       (IE_BIT),
    .EXL_BIT      (EXL_BIT),
    .ERL_BIT      (ERL_BIT),
    .CAUSE_KEEP   (CAUSE_KEEP),
    .STATUS_RESET (STATUS_RESET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .wr_en      (wr_en),
    .op_ei      (op_ei),
    .op_di      (op_di),
    .req_valid  (req_valid),
    .req_num    (req_num),
    .tmr_match  (tmr_match),
    .cmp_write  (cmp_write),
    .exc_enter  (exc_enter),
    .exc_return (exc_return),
    .dbg_mode   (dbg_mode),
    .status_w   (status_w),
    .cause_w    (cause_w),
    .irq_o      (irq_o)
);

// File: tb/cp_irq_unit_tb.sv
// Self-checking bench: a reference model of both registers is advanced
// arithmetically from the requirements and compared every cycle.
module cp_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        op_ei = 1'b0;
    logic        op_di = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        req_valid = 1'b0;
    logic [4:0]  req_num = '0;
    logic        req_level = 1'b0;
    logic        tmr_match = 1'b0;
    logic        cmp_write = 1'b0;
    logic        exc_enter = 1'b0;
    logic        exc_return = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        irq_o;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    logic [31:0] m_s;
    logic [31:0] m_c;

    always #10 clk = ~clk;

    cp_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .op_ei(op_ei), .op_di(op_di), .wr_data(wr_data), .rd_data(rd_data),
        .req_valid(req_valid), .req_num(req_num), .req_level(req_level),
        .tmr_match(tmr_match), .cmp_write(cmp_write), .exc_enter(exc_enter),
        .exc_return(exc_return), .dbg_mode(dbg_mode), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: predict, advance the model, then compare away from the edge.
    task automatic tick(input string tag);
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [31:0] s_n;
        logic [31:0] c_n;
        exp_irq = ((m_s & m_c & 32'h0000_FF00) != 0) && m_s[0] && !m_s[1]
                  && !m_s[2] && !dbg_mode;
        exp_rd  = (op_ei || op_di) ? m_s : (reg_sel ? m_c : m_s);
        c_n = (wr_en && reg_sel) ? ((m_c & 32'hB000_F87C) | (wr_data & 32'h00C0_0300)) : m_c;
        if (req_valid && req_num < 5'd16) c_n[int'(req_num) + 8] = req_level;
        if (tmr_match) c_n[15] = 1'b1;
        if (cmp_write) c_n[15] = 1'b0;
        s_n = m_s;
        if (wr_en && !reg_sel) s_n = (wr_data & 32'hFA78_FF01) | (m_s & 32'h0000_0006);
        else if (op_ei)        s_n = m_s | 32'h1;
        else if (op_di)        s_n = m_s & ~32'h1;
        if (exc_return) begin
            if (s_n[2]) s_n[2] = 1'b0;
            else        s_n[1] = 1'b0;
        end
        if (exc_enter) s_n[1] = 1'b1;
        @(posedge clk);
        m_s = s_n;
        m_c = c_n;
        @(negedge clk);
        check(tag, rd_data, exp_rd);
        check("R8", {31'b0, irq_o}, {31'b0, exp_irq});
        wr_en = 0; op_ei = 0; op_di = 0; req_valid = 0;
        tmr_match = 0; cmp_write = 0; exc_enter = 0; exc_return = 0;
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d, input string tag);
        reg_sel = sel; wr_en = 1; wr_data = d; tick(tag);
    endtask

    task automatic req(input int n, input logic lvl, input string tag);
        req_valid = 1; req_num = 5'(n); req_level = lvl; tick(tag);
    endtask

    task automatic peek(input logic sel, input string tag);
        reg_sel = sel; tick(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset values
        m_s = 32'h0000_0004;
        m_c = '0;
        repeat (3) @(negedge clk);
        check("R1", {31'b0, irq_o}, 32'h0);
        check("R1", rd_data, 32'h0);
        rst_n = 1'b1;
        peek(1'b0, "R1");
        peek(1'b1, "R1");
        peek(1'b0, "R1");
        // R11 / R8: error-level flag blocks a live request
        op_ei = 1; tick("R7");
        wr_reg(1'b0, 32'h0000_FF01, "R5");
        req(3, 1'b1, "R2");
        peek(1'b0, "R11");
        exc_return = 1; tick("R11");
        peek(1'b0, "R11");
        peek(1'b0, "R8");
        exc_enter = 1; tick("R11");
        peek(1'b0, "R8");
        exc_return = 1; tick("R11");
        peek(1'b0, "R8");
        dbg_mode = 1; peek(1'b0, "R8");
        peek(1'b0, "R8");
        dbg_mode = 0; peek(1'b0, "R8");
        exc_enter = 1; exc_return = 1; tick("R11");
        exc_return = 1; tick("R11");
        // R6 / R7: disable and enable return old Status
        op_di = 1; tick("R6");
        peek(1'b0, "R6");
        op_ei = 1; tick("R7");
        peek(1'b0, "R7");
        req(3, 1'b0, "R2");
        // R2: every request number, both levels
        for (int n = 0; n < 32; n++) begin
            req(n, 1'b1, "R2");
            peek(1'b1, "R2");
            req(n, 1'b0, "R2");
            peek(1'b1, "R2");
        end
        for (int n = 16; n < 32; n++) begin
            req(n, 1'b1, "R2");
        end
        peek(1'b1, "R2");
        // R3: timer events
        tmr_match = 1; tick("R3");
        peek(1'b1, "R3");
        cmp_write = 1; tick("R3");
        peek(1'b1, "R3");
        tmr_match = 1; cmp_write = 1; tick("R3");
        peek(1'b1, "R3");
        req_valid = 1; req_num = 5'd7; req_level = 1'b0; tmr_match = 1; tick("R3");
        req_valid = 1; req_num = 5'd7; req_level = 1'b1; cmp_write = 1; tick("R3");
        peek(1'b1, "R3");
        // R4: masked Cause writes with hardware lines held
        req(2, 1'b1, "R2");
        req(5, 1'b1, "R2");
        req(20, 1'b1, "R2");
        wr_reg(1'b1, 32'hFFFF_FFFF, "R4");
        peek(1'b1, "R4");
        wr_reg(1'b1, 32'h0000_0000, "R4");
        peek(1'b1, "R4");
        reg_sel = 1; wr_en = 1; wr_data = 32'h0000_0300;
        req_valid = 1; req_num = 5'd0; req_level = 1'b0; tick("R4");
        peek(1'b1, "R4");
        for (int n = 0; n < 8; n++) req(n, 1'b0, "R2");
        wr_reg(1'b1, 32'h0, "R4");
        // R5: Status write masking
        wr_reg(1'b0, 32'hFFFF_FFFF, "R5");
        peek(1'b0, "R5");
        wr_reg(1'b0, 32'h0000_0000, "R5");
        peek(1'b0, "R5");
        // R9: software pending bits
        wr_reg(1'b0, 32'h0000_0301, "R5");
        wr_reg(1'b1, 32'h0000_0100, "R9");
        peek(1'b1, "R9");
        wr_reg(1'b1, 32'h0000_0200, "R9");
        peek(1'b1, "R9");
        wr_reg(1'b0, 32'h0000_0101, "R9");
        peek(1'b1, "R9");
        wr_reg(1'b1, 32'h0, "R9");
        peek(1'b1, "R9");
        // R8: every enable mask against every single pending line
        for (int im = 0; im < 256; im++) begin
            for (int p = 0; p < 9; p++) begin
                wr_reg(1'b0, (32'(im) << 8) | 32'h1, "R10");
                if (p < 8) req(p, 1'b1, "R10");
                peek(1'b1, "R10");
                if (p < 8) req(p, 1'b0, "R10");
            end
        end
        // random mix of all inputs, one register operation per cycle
        for (int k = 0; k < 4000; k++) begin
            int unsigned op;
            op = $urandom_range(0, 5);
            reg_sel = 1'($urandom_range(0, 1));
            wr_data = $urandom;
            case (op)
                1: wr_en = 1;
                2: op_ei = 1;
                3: op_di = 1;
                default: ;
            endcase
            req_valid = ($urandom_range(0, 1) == 1);
            req_num   = 5'($urandom_range(0, 19));
            req_level = 1'($urandom_range(0, 1));
            tmr_match = ($urandom_range(0, 7) == 0);
            cmp_write = ($urandom_range(0, 7) == 0);
            exc_enter = ($urandom_range(0, 15) == 0);
            exc_return = ($urandom_range(0, 5) == 0);
            dbg_mode  = ($urandom_range(0, 7) == 0);
            tick("R10");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule